// File: doc/BRIEF.md
# Effective Address and Branch Target Unit

This block computes the operand address of a memory-referencing instruction, or the destination and outcome of a conditional branch, for a processor with 16-bit addresses and 8-bit data. The decoder supplies the addressing mode and the second and third instruction bytes. The register file supplies the index register. The fetch stage supplies the program counter value after the whole instruction has been fetched. The block drives one 16-bit address. For branches it also drives a taken flag, which it finds by testing the selected condition against the condition code flags.

The unit is purely combinational, so the address and the taken flag follow the inputs within the same cycle. Indexed addressing adds the offset on a private adder and never writes back to the index register. The same indexed path serves operand fetches and indexed subroutine calls. All address arithmetic wraps modulo 65536.

Top module: `ea_branch_unit`

## Requirements
- R1: With mode code 0 (direct), the address is 0x00 in the high byte and byte 2 in the low byte, so only 0x0000 to 0x00FF can be reached.
- R2: With mode code 1 (extended), the address is byte 2 as the high byte and byte 3 as the low byte.
- R3: With mode code 2 (indexed), the address is the index value plus byte 2 taken as unsigned, modulo 65536. A carry out of the low byte raises the high byte by one. Examples: 0x1000+0x10 gives 0x1010, 0x1100+0x30 gives 0x1130, 0x10F0+0x20 gives 0x1110, 0xFFFF+0x01 gives 0x0000.
- R4: With mode code 3 (relative), the address is the post-fetch program counter plus byte 2 sign-extended. Offsets 0x00 to 0x7F move forward, for example 0x000B+0x04 gives 0x000F and 0x0100+0x7F gives 0x017F.
- R5: Relative offsets 0x80 to 0xFF move backward by 256 minus the offset, with wrap. For example 0x010E+0xF7 gives 0x0105, 0x0100+0x80 gives 0x0080, and 0x0005+0xF0 gives 0xFFF5.
- R6: The flag input places C at bit 0, V at bit 1, Z at bit 2 and N at bit 3. Bits 4 to 7 never affect any output.
- R7: Condition codes 0 and 1 are always and never. Codes 6 and 7 are Z clear and Z set. Codes 4 and 5 are C clear and C set. Codes 8 and 9 are V clear and V set. Codes 10 and 11 are N clear and N set.
- R8: Code 2 (unsigned higher) holds when C and Z are both 0. Code 3 (unsigned lower or same) holds when C or Z is 1.
- R9: Code 12 holds when N equals V. Code 13 holds when N differs from V. Code 14 holds when Z is 0 and N equals V. Code 15 holds when Z is 1 or N differs from V.
- R10: The taken output equals the condition result in relative mode and is 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Addressing mode: 0 direct, 1 extended, 2 indexed, 3 relative |
| byte2_i | input | 8 | Second instruction byte (address, offset or high address byte) |
| byte3_i | input | 8 | Third instruction byte (low address byte in extended mode) |
| index_i | input | 16 | Current index register value |
| pc_next_i | input | 16 | Program counter after the instruction has been fetched |
| cond_i | input | 4 | Branch condition select |
| ccr_i | input | 8 | Condition code flags (C bit 0, V bit 1, Z bit 2, N bit 3) |
| addr_o | output | 16 | Effective address or branch target |
| taken_o | output | 1 | Branch decision, valid in relative mode |

## Verification
Indexed offsets are swept both with and without a low-byte carry and at the top of memory. This separates a correct carry into the high byte from one that is dropped or fed into the wrong place. Relative offsets are tried at 0x7F, 0x80 and 0xFF, which exposes a zero-extended or a wrongly extended offset. A backward branch across address zero exercises the wrap. Every condition code is run against all sixteen flag combinations. That tells apart each signed test from its unsigned counterpart, and each test from its inverse. Repeats with the upper flag bits set, and in the non-branch modes, show that those inputs cannot change the result.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_EXTENDED = 2'd1,
    AM_INDEXED  = 2'd2,
    AM_RELATIVE = 2'd3
  } addr_mode_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;

  // Test on the even code of a pair; the odd code is its inverse.
  function automatic logic base_test(input logic [2:0] pair, input logic [7:0] f);
    logic n, z, v, c;
    n = f[FLAG_N];
    z = f[FLAG_Z];
    v = f[FLAG_V];
    c = f[FLAG_C];
    case (pair)
      3'd0:    base_test = 1'b1;
      3'd1:    base_test = ~(c | z);
      3'd2:    base_test = ~c;
      3'd3:    base_test = ~z;
      3'd4:    base_test = ~v;
      3'd5:    base_test = ~n;
      3'd6:    base_test = ~(n ^ v);
      default: base_test = ~z & ~(n ^ v);
    endcase
  endfunction

endpackage

// File: rtl/ea_index_adder.sv
module ea_index_adder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] off_i,
  output logic [ADDR_W-1:0] sum_o,
  output logic              lo_carry_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W:0]   lo_sum;
  logic [HI_W-1:0]   hi_sum;

  always_comb begin
    lo_sum = {1'b0, base_i[DATA_W-1:0]} + {1'b0, off_i};
    hi_sum = base_i[ADDR_W-1:DATA_W] + HI_W'(lo_sum[DATA_W]);
  end

  assign sum_o      = {hi_sum, lo_sum[DATA_W-1:0]};
  assign lo_carry_o = lo_sum[DATA_W];
endmodule

// File: rtl/ea_rel_adder.sv
module ea_rel_adder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] off_i,
  output logic [ADDR_W-1:0] target_o,
  output logic              backward_o
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] off_ext;

  assign backward_o = off_i[DATA_W-1];
  assign off_ext    = {{EXT_W{off_i[DATA_W-1]}}, off_i};
  assign target_o   = pc_i + off_ext;
endmodule

// File: rtl/ea_cond_eval.sv
module ea_cond_eval
  import ea_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic [7:0] ccr_i,
  output logic       hold_o
);
  logic [7:0] flags_low;

  // Only the four arithmetic flags take part in any test.
  assign flags_low = {4'b0000, ccr_i[3:0]};
  assign hold_o    = base_test(cond_i[3:1], flags_low) ^ cond_i[0];
endmodule

// File: rtl/ea_branch_unit.sv
module ea_branch_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [1:0]        mode_i,
  input  logic [7:0]        byte2_i,
  input  logic [7:0]        byte3_i,
  input  logic [15:0]       index_i,
  input  logic [15:0]       pc_next_i,
  input  logic [3:0]        cond_i,
  input  logic [7:0]        ccr_i,
  output logic [15:0]       addr_o,
  output logic              taken_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  addr_mode_e        mode;
  logic [ADDR_W-1:0] direct_addr;
  logic [ADDR_W-1:0] ext_addr;
  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] rel_addr;
  logic              idx_carry;
  logic              rel_back;
  logic              cond_hold;

  assign mode        = addr_mode_e'(mode_i);
  assign direct_addr = {{HI_W{1'b0}}, byte2_i};
  assign ext_addr    = ADDR_W'({byte2_i, byte3_i});

  ea_index_adder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idx (
    .base_i     (index_i),
    .off_i      (byte2_i),
    .sum_o      (idx_addr),
    .lo_carry_o (idx_carry)
  );

  ea_rel_adder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rel (
    .pc_i       (pc_next_i),
    .off_i      (byte2_i),
    .target_o   (rel_addr),
    .backward_o (rel_back)
  );

  ea_cond_eval u_cond (
    .cond_i (cond_i),
    .ccr_i  (ccr_i),
    .hold_o (cond_hold)
  );

  always_comb begin
    unique case (mode)
      AM_DIRECT:   addr_o = direct_addr;
      AM_EXTENDED: addr_o = ext_addr;
      AM_INDEXED:  addr_o = idx_addr;
      default:     addr_o = rel_addr;
    endcase
    taken_o = (mode == AM_RELATIVE) && cond_hold;
  end
endmodule

// File: rtl/ea_branch_checker.sv
module ea_branch_checker (
  input logic [1:0]  mode_i,
  input logic [7:0]  byte2_i,
  input logic [7:0]  byte3_i,
  input logic [15:0] index_i,
  input logic [15:0] pc_next_i,
  input logic [3:0]  cond_i,
  input logic [7:0]  ccr_i,
  input logic [15:0] addr_o,
  input logic        taken_o,
  input logic        idx_carry,
  input logic        rel_back,
  input logic        cond_hold
);
  logic known;
  assign known = !$isunknown({mode_i, byte2_i, byte3_i, index_i, pc_next_i, cond_i, ccr_i});

  always_comb begin
    if (known) begin
      if (mode_i == 2'd0)
        p_direct_page_r1: assert (addr_o[15:8] == 8'h00 && addr_o[7:0] == byte2_i)
          else $error("direct address outside page zero");
      if (mode_i == 2'd1)
        p_extended_bytes_r2: assert (addr_o[15:8] == byte2_i && addr_o[7:0] == byte3_i)
          else $error("extended address byte order");
      if (mode_i == 2'd2)
        p_index_offset_r3: assert (16'(addr_o - index_i) == {8'h00, byte2_i})
          else $error("indexed distance wrong");
      if (mode_i == 2'd2 && idx_carry)
        p_index_carry_r3: assert (addr_o[15:8] == 8'(index_i[15:8] + 8'd1))
          else $error("low-byte carry not propagated");
      if (mode_i == 2'd3 && !rel_back)
        p_forward_r4: assert (16'(addr_o - pc_next_i) == {8'h00, byte2_i})
          else $error("forward branch distance wrong");
      if (mode_i == 2'd3 && rel_back)
        p_backward_r5: assert (16'(pc_next_i - addr_o) == 16'(16'd256 - {8'h00, byte2_i}))
          else $error("backward branch distance wrong");
      if (mode_i != 2'd3)
        p_no_take_r10: assert (!taken_o)
          else $error("taken outside relative mode");
      if (mode_i == 2'd3)
        p_take_follows_r10: assert (taken_o == cond_hold)
          else $error("taken differs from condition");
      if (cond_i == 4'd0)
        p_always_r7: assert (cond_hold)
          else $error("always condition false");
      if (cond_i == 4'd1)
        p_never_r7: assert (!cond_hold)
          else $error("never condition true");
    end
  end
endmodule

bind ea_branch_unit ea_branch_checker u_ea_chk (
  .mode_i    (mode_i),
  .byte2_i   (byte2_i),
  .byte3_i   (byte3_i),
  .index_i   (index_i),
  .pc_next_i (pc_next_i),
  .cond_i    (cond_i),
  .ccr_i     (ccr_i),
  .addr_o    (addr_o),
  .taken_o   (taken_o),
  .idx_carry (idx_carry),
  .rel_back  (rel_back),
  .cond_hold (cond_hold)
);

// File: tb/test_ea_branch_unit.sv
module test_ea_branch_unit;
  logic        clk = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [7:0]  byte2_i = 8'h00;
  logic [7:0]  byte3_i = 8'h00;
  logic [15:0] index_i = 16'h0000;
  logic [15:0] pc_next_i = 16'h0000;
  logic [3:0]  cond_i = 4'd0;
  logic [7:0]  ccr_i = 8'h00;
  logic [15:0] addr_o;
  logic        taken_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ea_branch_unit i_ea_branch_unit (
    .mode_i    (mode_i),
    .byte2_i   (byte2_i),
    .byte3_i   (byte3_i),
    .index_i   (index_i),
    .pc_next_i (pc_next_i),
    .cond_i    (cond_i),
    .ccr_i     (ccr_i),
    .addr_o    (addr_o),
    .taken_o   (taken_o)
  );

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic chk_addr(input string req, input logic [15:0] exp);
    total++;
    if (addr_o !== exp) begin
      bad++;
      $display("FAIL %s addr actual=%h expected=%h", req, addr_o, exp);
    end
  endtask

  task automatic chk_take(input string req, input logic exp);
    total++;
    if (taken_o !== exp) begin
      bad++;
      $display("FAIL %s taken actual=%b expected=%b (cond=%0d ccr=%h mode=%0d)",
               req, taken_o, exp, cond_i, ccr_i, mode_i);
    end
  endtask

  // Reference condition, written from the requirement table.
  function automatic logic ref_cond(input int code, input logic [7:0] f);
    logic c, v, z, n;
    c = f[0]; v = f[1]; z = f[2]; n = f[3];
    case (code)
      0: return 1'b1;
      1: return 1'b0;
      2: return (c == 1'b0) && (z == 1'b0);
      3: return c || z;
      4: return !c;
      5: return c;
      6: return !z;
      7: return z;
      8: return !v;
      9: return v;
      10: return !n;
      11: return n;
      12: return n == v;
      13: return n != v;
      14: return (z == 1'b0) && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  function automatic logic [15:0] ref_rel(input logic [15:0] pc, input logic [7:0] off);
    int t;
    t = int'(pc) + ((off >= 8'h80) ? int'(off) - 256 : int'(off));
    return 16'(t & 16'hFFFF);
  endfunction

  task automatic t_reset_state();
    settle();
    chk_addr("R1 initial", 16'h0000);
    chk_take("R10 initial", 1'b0);
  endtask

  task automatic t_direct();
    mode_i = 2'd0; index_i = 16'hABCD; pc_next_i = 16'h1234; byte3_i = 8'h77;
    byte2_i = 8'h25; settle(); chk_addr("R1", 16'h0025);
    byte2_i = 8'hFF; settle(); chk_addr("R1", 16'h00FF);
  endtask

  task automatic t_extended();
    mode_i = 2'd1;
    byte2_i = 8'h10; byte3_i = 8'h00; settle(); chk_addr("R2", 16'h1000);
    byte2_i = 8'h3F; byte3_i = 8'hF2; settle(); chk_addr("R2", 16'h3FF2);
  endtask

  task automatic t_indexed();
    mode_i = 2'd2;
    index_i = 16'h1000; byte2_i = 8'h10; settle(); chk_addr("R3", 16'h1010);
    index_i = 16'h1100; byte2_i = 8'h30; settle(); chk_addr("R3", 16'h1130);
    index_i = 16'h10F0; byte2_i = 8'h20; settle(); chk_addr("R3", 16'h1110);
    index_i = 16'h050D; byte2_i = 8'h16; settle(); chk_addr("R3", 16'h0523);
    index_i = 16'h0100; byte2_i = 8'h80; settle(); chk_addr("R3", 16'h0180);
    index_i = 16'hFFFF; byte2_i = 8'h01; settle(); chk_addr("R3", 16'h0000);
    for (int o = 0; o < 256; o += 17) begin
      index_i = 16'h12E0; byte2_i = 8'(o); settle();
      chk_addr("R3 sweep", 16'(16'h12E0 + o));
    end
  endtask

  task automatic t_forward();
    mode_i = 2'd3; cond_i = 4'd0; ccr_i = 8'h00;
    pc_next_i = 16'h000B; byte2_i = 8'h04; settle(); chk_addr("R4", 16'h000F);
    pc_next_i = 16'h0100; byte2_i = 8'h7F; settle(); chk_addr("R4", 16'h017F);
    pc_next_i = 16'h0105; byte2_i = 8'h04; settle(); chk_addr("R4", 16'h0109);
    pc_next_i = 16'hFFFE; byte2_i = 8'h05; settle(); chk_addr("R4", 16'h0003);
  endtask

  task automatic t_backward();
    mode_i = 2'd3;
    pc_next_i = 16'h010E; byte2_i = 8'hF7; settle(); chk_addr("R5", 16'h0105);
    pc_next_i = 16'h0100; byte2_i = 8'h80; settle(); chk_addr("R5", 16'h0080);
    pc_next_i = 16'h0005; byte2_i = 8'hF0; settle(); chk_addr("R5", 16'hFFF5);
    pc_next_i = 16'h2000; byte2_i = 8'hFF; settle(); chk_addr("R5", 16'h1FFF);
    for (int o = 120; o < 136; o++) begin
      pc_next_i = 16'h4000; byte2_i = 8'(o); settle();
      chk_addr("R5 boundary", ref_rel(16'h4000, 8'(o)));
    end
  endtask

  task automatic t_conditions();
    mode_i = 2'd3; pc_next_i = 16'h0200; byte2_i = 8'h10;
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        cond_i = 4'(code); ccr_i = 8'(f); settle();
        if (code < 2 || (code >= 4 && code < 12))
          chk_take("R7", ref_cond(code, 8'(f)));
        else if (code < 4)
          chk_take("R8", ref_cond(code, 8'(f)));
        else
          chk_take("R9", ref_cond(code, 8'(f)));
      end
    end
  endtask

  task automatic t_upper_flags();
    mode_i = 2'd3; pc_next_i = 16'h0300; byte2_i = 8'h02;
    for (int code = 0; code < 16; code++) begin
      cond_i = 4'(code);
      ccr_i = 8'hF0; settle();
      chk_take("R6 upper bits ignored", ref_cond(code, 8'h00));
      ccr_i = 8'hA5; settle();
      chk_take("R6 upper bits ignored", ref_cond(code, 8'h05));
    end
    chk_addr("R6 address unaffected", 16'h0302);
  endtask

  task automatic t_no_take();
    cond_i = 4'd0; ccr_i = 8'hFF; byte2_i = 8'h40; byte3_i = 8'h01; index_i = 16'h0010;
    for (int m = 0; m < 3; m++) begin
      mode_i = 2'(m); settle();
      chk_take("R10 non-relative", 1'b0);
    end
    mode_i = 2'd3; settle(); chk_take("R10 relative", 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_direct();
    t_extended();
    t_indexed();
    t_forward();
    t_backward();
    t_conditions();
    t_upper_flags();
    t_no_take();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule